// File: doc/BRIEF.md
# ADC Channel Sequencer Controller

This block chooses, for every conversion of a multi-channel sampling converter, which input channel the front-end multiplexer selects and how that input is configured (single-ended or differential, unipolar or bipolar). A two-bit mode input selects where that choice comes from. It can come straight from external pins. It can come from a free-running scan counter. It can come from a small sequence memory that is first written and read back through active-low write and read strobes, and then replayed one entry per conversion start. The converter is represented only by its idle flag: each accepted conversion start holds the block busy for a fixed number of clocks. When the conversion completes, the channel that was actually converted is presented as a tag next to the result.

The strobes, the mode pins and the external address and configuration pins are asynchronous to the system clock. They are synchronised before use, and the strobes are edge-detected. A central state machine has four states: ST_DIRECT, ST_SCAN, ST_SEQ_EDIT and ST_SEQ_RUN. Its state register always takes the state decoded from the synchronised mode pins. Any change of state (for example ST_SEQ_RUN to ST_SCAN, ST_SCAN to ST_SEQ_RUN, or ST_SEQ_EDIT to ST_SEQ_RUN) is a "mode change" transition. That transition clears every pointer and the scan counter and leaves the sequence memory untouched. A separate conversion timer moves through TM_IDLE, TM_CONV and TM_DONE: TM_IDLE goes to TM_CONV on an accepted start, TM_CONV goes to TM_DONE when its count expires, and TM_DONE goes back to TM_IDLE while publishing the tag.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While reset is asserted and right after it, mux_addr, mux_cfg, result_tag, seq_rd_data and seq_rd_oe are 0, tag_valid is 0 and busy is 1 (idle).
- R2: With mode_sel=00 (direct), the active entry follows ext_addr/ext_cfg while wr_n is low, and it is captured on a rising wr_n or an accepted falling convst_n. With wr_n high and no strobe, pin changes do not reach mux_addr.
- R3: With mode_sel=01 (scan), the address comes from an internal counter that starts at 0, advances by one after each accepted conversion and wraps from 7 to 0. The configuration follows the R2 rule.
- R4: With mode_sel=10 (edit), a rising wr_n stores {ext_addr, ext_cfg} at the write pointer and advances it. The last location written becomes the end of the run sequence.
- R5: In edit mode a falling rd_n drives the entry at the read pointer onto seq_rd_data, with seq_rd_data[4:2]=address and [1:0]=configuration, and raises seq_rd_oe. A rising rd_n lowers seq_rd_oe and advances the read pointer.
- R6: With mode_sel=11 (run), each accepted conversion loads the entry at the run pointer, starting at location 0. After the last programmed location the pointer returns to 0.
- R7: Any change of the synchronised mode clears the write, read and run pointers and the scan counter.
- R8: Sequence memory contents survive switches to other modes and back.
- R9: tag_valid pulses for one cycle exactly BUSY_CYCLES+1 clocks after the edge that accepts a conversion. In that cycle result_tag shows the converted multiplexer address, never the pointer, and result_tag changes at no other time.
- R10: A falling convst_n while busy is low is ignored: it gives no new conversion, no pointer or counter advance and no address change.
- R11: In edit mode a falling convst_n starts no conversion, and busy stays high.
- R12: A pin or strobe change takes effect on the third rising clock edge after it, and not earlier.
- Configuration bit 1 means differential and bit 0 means bipolar. mode_sel encodes 00 direct, 01 scan, 10 edit and 11 run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Mode select: 00 direct, 01 scan, 10 edit, 11 run |
| wr_n | input | 1 | Active-low write/capture strobe |
| rd_n | input | 1 | Active-low readback strobe |
| convst_n | input | 1 | Active-low conversion start |
| ext_addr | input | ADDR_W | External channel address |
| ext_cfg | input | CFG_W | External configuration (bit1 differential, bit0 bipolar) |
| mux_addr | output | ADDR_W | Active multiplexer address |
| mux_cfg | output | CFG_W | Active input configuration |
| seq_rd_data | output | ADDR_W+CFG_W | Sequence entry read back, {address, configuration} |
| seq_rd_oe | output | 1 | High while a readback entry is driven |
| result_tag | output | ADDR_W | Address of the channel converted for the latest result |
| tag_valid | output | 1 | One-cycle pulse when result_tag is updated |
| busy | output | 1 | High when the converter is idle and accepts a start |

## Verification
The bench goes after the places where a small slip only shows up much later. The run pointer must wrap after the last location actually programmed: a design that wraps at memory depth would replay stale entries. The pointers must reset on a mode change: without that, a return to run mode would resume mid-sequence. A start arriving while the converter is busy must be dropped: honouring it would skip a scan channel or a sequence entry. A shorter reprogramming pass must shorten the sequence while keeping the older entries stored. Each result tag is compared against the converted channel, so a design that tagged with the pointer would fail in both scan and run order. The three-edge input latency is probed one cycle before and one cycle at the point of effect.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    // Controller states; the encoding equals the mode pin code.
    typedef enum logic [1:0] {
        ST_DIRECT   = 2'b00,
        ST_SCAN     = 2'b01,
        ST_SEQ_EDIT = 2'b10,
        ST_SEQ_RUN  = 2'b11
    } ctl_state_e;

    // Converter timing model states.
    typedef enum logic [1:0] {
        TM_IDLE = 2'b00,
        TM_CONV = 2'b01,
        TM_DONE = 2'b10
    } tmr_state_e;

    function automatic ctl_state_e decode_mode(input logic [1:0] pins);
        ctl_state_e s;
        unique case (pins)
            2'b00:   s = ST_DIRECT;
            2'b01:   s = ST_SCAN;
            2'b10:   s = ST_SEQ_EDIT;
            default: s = ST_SEQ_RUN;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/adc_strobe_sync.sv
// Two-flop synchroniser for active-low strobes plus one extra stage so the
// parent can detect edges. Every stage resets to the inactive (high) level.
module adc_strobe_sync #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] strobe_n,
    output logic [N-1:0] level,
    output logic [N-1:0] prev
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic meta_q;
        logic sync_q;
        logic last_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b1;
                sync_q <= 1'b1;
                last_q <= 1'b1;
            end else begin
                meta_q <= strobe_n[i];
                sync_q <= meta_q;
                last_q <= sync_q;
            end
        end

        assign level[i] = sync_q;
        assign prev[i]  = last_q;
    end

endmodule

// File: rtl/adc_bus_sync.sv
// Two-flop synchroniser for quasi-static level pins (mode, address, config).
module adc_bus_sync #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
        end
    end

    assign dout = sync_q;

endmodule

// File: rtl/adc_seq_mem.sv
// Sequence storage: one write port, two independent read ports (readback and
// run), and a register holding the last location written.
module adc_seq_mem #(
    parameter int DEPTH = 16,
    parameter int EW    = 5,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [PW-1:0] waddr,
    input  logic [EW-1:0] wdata,
    input  logic [PW-1:0] raddr_a,
    input  logic [PW-1:0] raddr_b,
    output logic [EW-1:0] rdata_a,
    output logic [EW-1:0] rdata_b,
    output logic [PW-1:0] last_idx
);

    logic [DEPTH-1:0][EW-1:0] store_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            store_q  <= '0;
            last_idx <= '0;
        end else if (we) begin
            store_q[waddr] <= wdata;
            last_idx       <= waddr;
        end
    end

    assign rdata_a = store_q[raddr_a];
    assign rdata_b = store_q[raddr_b];

endmodule

// File: rtl/adc_conv_timer.sv
// Behavioural stand-in for the converter: an accepted start keeps the block
// busy for BUSY_CYCLES+1 clocks, then the captured channel tag is published.
module adc_conv_timer
    import adc_seq_pkg::*;
#(
    parameter int BUSY_CYCLES = 6,
    parameter int TAG_W       = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [TAG_W-1:0] tag_in,
    output logic             idle,
    output logic [TAG_W-1:0] tag_out,
    output logic             tag_valid
);

    localparam int            CW   = $clog2(BUSY_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(BUSY_CYCLES - 1);

    tmr_state_e       st_q, st_d;
    logic [CW-1:0]    cnt_q;
    logic [TAG_W-1:0] hold_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TM_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TM_IDLE: if (start)        st_d = TM_CONV;
            TM_CONV: if (cnt_q == '0)  st_d = TM_DONE;
            TM_DONE:                   st_d = TM_IDLE;
            default:                   st_d = TM_IDLE;
        endcase
    end

    // Outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            hold_q    <= '0;
            tag_out   <= '0;
            tag_valid <= 1'b0;
        end else begin
            tag_valid <= (st_q == TM_DONE);
            if (st_q == TM_IDLE && start) begin
                cnt_q  <= LOAD;
                hold_q <= tag_in;
            end else if (st_q == TM_CONV && cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
            if (st_q == TM_DONE) tag_out <= hold_q;
        end
    end

    assign idle = (st_q == TM_IDLE);

endmodule

// File: rtl/adc_seq_ctrl.sv
// Top: mode state machine, pointer logic and active-entry selection.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int ADDR_W      = 3,
    parameter int CFG_W       = 2,
    parameter int DEPTH       = 16,
    parameter int BUSY_CYCLES = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              mode_sel,
    input  logic                    wr_n,
    input  logic                    rd_n,
    input  logic                    convst_n,
    input  logic [ADDR_W-1:0]       ext_addr,
    input  logic [CFG_W-1:0]        ext_cfg,
    output logic [ADDR_W-1:0]       mux_addr,
    output logic [CFG_W-1:0]        mux_cfg,
    output logic [ADDR_W+CFG_W-1:0] seq_rd_data,
    output logic                    seq_rd_oe,
    output logic [ADDR_W-1:0]       result_tag,
    output logic                    tag_valid,
    output logic                    busy
);

    localparam int EW = ADDR_W + CFG_W;
    localparam int PW = $clog2(DEPTH);
    localparam int SW = 2 + EW;

    // ---------------- input conditioning ----------------
    logic [2:0] stb_lvl, stb_prev;
    logic [SW-1:0] pins_s;

    adc_strobe_sync #(.N(3)) u_stb (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_n ({convst_n, rd_n, wr_n}),
        .level    (stb_lvl),
        .prev     (stb_prev)
    );

    adc_bus_sync #(.W(SW)) u_pins (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({mode_sel, ext_addr, ext_cfg}),
        .dout  (pins_s)
    );

    logic          wr_low, wr_rise, rd_fall, rd_rise, cv_fall;
    logic [1:0]    mode_s;
    logic [EW-1:0] ext_s;

    assign wr_low  = ~stb_lvl[0];
    assign wr_rise =  stb_lvl[0] & ~stb_prev[0];
    assign rd_fall = ~stb_lvl[1] &  stb_prev[1];
    assign rd_rise =  stb_lvl[1] & ~stb_prev[1];
    assign cv_fall = ~stb_lvl[2] &  stb_prev[2];
    assign mode_s  = pins_s[SW-1 -: 2];
    assign ext_s   = pins_s[EW-1:0];

    // ---------------- mode state machine ----------------
    ctl_state_e state_q, mode_req;
    logic       mode_chg;

    assign mode_req = decode_mode(mode_s);
    assign mode_chg = (mode_req != state_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_DIRECT;
        else        state_q <= mode_req;
    end

    // ---------------- shared datapath ----------------
    logic [EW-1:0]     act_q, act_d;
    logic [ADDR_W-1:0] scan_q, scan_d;
    logic [PW-1:0]     run_q, run_d;
    logic [PW-1:0]     wr_ptr_q, rd_ptr_q;
    logic [EW-1:0]     rd_entry, run_entry;
    logic [PW-1:0]     last_idx;
    logic              conv_idle, accept, capture, mem_we;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign accept  = cv_fall & conv_idle & ~mode_chg & (state_q != ST_SEQ_EDIT);
    assign capture = wr_low | wr_rise | accept;
    assign mem_we  = ~mode_chg & (state_q == ST_SEQ_EDIT) & wr_rise;

    adc_seq_mem #(.DEPTH(DEPTH), .EW(EW)) u_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (mem_we),
        .waddr    (wr_ptr_q),
        .wdata    (ext_s),
        .raddr_a  (rd_ptr_q),
        .raddr_b  (run_q),
        .rdata_a  (rd_entry),
        .rdata_b  (run_entry),
        .last_idx (last_idx)
    );

    // Next active entry, scan counter and run pointer
    always_comb begin
        act_d  = act_q;
        scan_d = scan_q;
        run_d  = run_q;
        unique case (state_q)
            ST_DIRECT: begin
                if (capture) act_d = ext_s;
            end
            ST_SCAN: begin
                if (capture) act_d  = {scan_q, ext_s[CFG_W-1:0]};
                if (accept)  scan_d = scan_q + 1'b1;
            end
            ST_SEQ_EDIT: begin
                act_d = act_q;
            end
            ST_SEQ_RUN: begin
                if (accept) begin
                    act_d = run_entry;
                    run_d = (run_q == last_idx) ? '0 : run_q + 1'b1;
                end
            end
        endcase
        if (mode_chg) begin
            act_d  = act_q;
            scan_d = '0;
            run_d  = '0;
        end
    end

    // Registered outputs of the state machine
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q       <= '0;
            scan_q      <= '0;
            run_q       <= '0;
            wr_ptr_q    <= '0;
            rd_ptr_q    <= '0;
            seq_rd_oe   <= 1'b0;
            seq_rd_data <= '0;
        end else begin
            act_q  <= act_d;
            scan_q <= scan_d;
            run_q  <= run_d;
            if (mode_chg) begin
                wr_ptr_q  <= '0;
                rd_ptr_q  <= '0;
                seq_rd_oe <= 1'b0;
            end else if (state_q == ST_SEQ_EDIT) begin
                if (wr_rise) wr_ptr_q <= bump(wr_ptr_q);
                if (rd_fall) begin
                    seq_rd_data <= rd_entry;
                    seq_rd_oe   <= 1'b1;
                end
                if (rd_rise) begin
                    seq_rd_oe <= 1'b0;
                    rd_ptr_q  <= bump(rd_ptr_q);
                end
            end
        end
    end

    // ---------------- converter model ----------------
    adc_conv_timer #(.BUSY_CYCLES(BUSY_CYCLES), .TAG_W(ADDR_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .tag_in    (act_d[EW-1:CFG_W]),
        .idle      (conv_idle),
        .tag_out   (result_tag),
        .tag_valid (tag_valid)
    );

    assign busy     = conv_idle;
    assign mux_addr = act_q[EW-1:CFG_W];
    assign mux_cfg  = act_q[CFG_W-1:0];

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
    parameter int BUSY_CYCLES = 6,
    parameter int AW          = 3,
    parameter int EW          = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          tag_valid,
    input logic [AW-1:0] result_tag,
    input logic          seq_rd_oe,
    input logic [EW-1:0] seq_rd_data
);

    logic [15:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    low_cnt <= '0;
        else if (busy) low_cnt <= '0;
        else           low_cnt <= low_cnt + 1'b1;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_idle_R1: assert (busy && !tag_valid && !seq_rd_oe)
                else $error("reset state wrong");
        end
    end

    assert_busy_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (low_cnt == 16'(BUSY_CYCLES + 1)));

    assert_tag_on_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> tag_valid);

    assert_tag_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tag_valid |=> !tag_valid);

    assert_tag_only_on_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result_tag) |-> tag_valid);

    assert_no_tag_while_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tag_valid |-> busy);

    assert_readback_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_rd_oe && $past(seq_rd_oe)) |-> $stable(seq_rd_data));

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(
    .BUSY_CYCLES (BUSY_CYCLES),
    .AW          (ADDR_W),
    .EW          (ADDR_W + CFG_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .tag_valid   (tag_valid),
    .result_tag  (result_tag),
    .seq_rd_oe   (seq_rd_oe),
    .seq_rd_data (seq_rd_data)
);

// File: tb/tb_adc_seq_ctrl.sv
module tb_adc_seq_ctrl;

    localparam int B = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic       wr_n = 1'b1, rd_n = 1'b1, convst_n = 1'b1;
    logic [2:0] ext_addr = '0;
    logic [1:0] ext_cfg = '0;
    logic [2:0] mux_addr, result_tag;
    logic [1:0] mux_cfg;
    logic [4:0] seq_rd_data;
    logic       seq_rd_oe, tag_valid, busy;

    always #2.5 clk = ~clk;

    adc_seq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .wr_n(wr_n), .rd_n(rd_n),
        .convst_n(convst_n), .ext_addr(ext_addr), .ext_cfg(ext_cfg),
        .mux_addr(mux_addr), .mux_cfg(mux_cfg), .seq_rd_data(seq_rd_data),
        .seq_rd_oe(seq_rd_oe), .result_tag(result_tag), .tag_valid(tag_valid),
        .busy(busy)
    );

    int total = 0, bad = 0;
    bit done = 1'b0;

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_mem[16];
    int m_last, m_wp, m_rp, m_run, m_scan, m_act, m_rdd, m_oe, m_bcnt, m_pend, m_tag, m_tv;
    int h_wr[3], h_rd[3], h_cv[3], h_md[3], h_ex[3];
    int md, ex;
    bit wr_rise_m, rd_fall_m, rd_rise_m, cv_fall_m, chg_m, acc_m, upd_m;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) m_mem[i] = 0;
            m_last = 0; m_wp = 0; m_rp = 0; m_run = 0; m_scan = 0; m_act = 0;
            m_rdd = 0; m_oe = 0; m_bcnt = 0; m_pend = 0; m_tag = 0; m_tv = 0;
            for (int i = 0; i < 3; i++) begin
                h_wr[i] = 1; h_rd[i] = 1; h_cv[i] = 1; h_md[i] = 0; h_ex[i] = 0;
            end
        end else begin
            // inputs seen through the three-edge input latency (R12)
            wr_rise_m = (h_wr[1] == 1) && (h_wr[2] == 0);
            rd_fall_m = (h_rd[1] == 0) && (h_rd[2] == 1);
            rd_rise_m = (h_rd[1] == 1) && (h_rd[2] == 0);
            cv_fall_m = (h_cv[1] == 0) && (h_cv[2] == 1);
            chg_m     = (h_md[1] != h_md[2]);
            md        = h_md[2];
            ex        = h_ex[1];
            acc_m     = cv_fall_m && (m_bcnt == 0) && !chg_m && (md != 2);
            upd_m     = (h_wr[1] == 0) || wr_rise_m || acc_m;
            m_tv = 0;
            if (m_bcnt > 0) begin
                m_bcnt--;
                if (m_bcnt == 0) begin m_tag = m_pend; m_tv = 1; end
            end
            if (chg_m) begin
                m_wp = 0; m_rp = 0; m_run = 0; m_scan = 0; m_oe = 0;
            end else begin
                case (md)
                    0: if (upd_m) m_act = ex;
                    1: begin
                        if (upd_m) m_act = m_scan * 4 + ex % 4;
                        if (acc_m) m_scan = (m_scan + 1) % 8;
                    end
                    2: begin
                        if (rd_fall_m) begin m_rdd = m_mem[m_rp]; m_oe = 1; end
                        if (rd_rise_m) begin m_oe = 0; m_rp = (m_rp + 1) % 16; end
                        if (wr_rise_m) begin
                            m_mem[m_wp] = ex; m_last = m_wp; m_wp = (m_wp + 1) % 16;
                        end
                    end
                    default: if (acc_m) begin
                        m_act = m_mem[m_run];
                        m_run = (m_run == m_last) ? 0 : m_run + 1;
                    end
                endcase
            end
            if (acc_m) begin m_bcnt = B + 1; m_pend = m_act / 4; end
            for (int i = 2; i > 0; i--) begin
                h_wr[i] = h_wr[i-1]; h_rd[i] = h_rd[i-1]; h_cv[i] = h_cv[i-1];
                h_md[i] = h_md[i-1]; h_ex[i] = h_ex[i-1];
            end
            h_wr[0] = wr_n; h_rd[0] = rd_n; h_cv[0] = convst_n;
            h_md[0] = mode_sel; h_ex[0] = ext_addr * 4 + ext_cfg;
        end
    end

    // every-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            case (md)
                0:       chk("R2 active entry", mux_addr * 4 + mux_cfg, m_act);
                1:       chk("R3 active entry", mux_addr * 4 + mux_cfg, m_act);
                2:       chk("R4 active entry", mux_addr * 4 + mux_cfg, m_act);
                default: chk("R6 active entry", mux_addr * 4 + mux_cfg, m_act);
            endcase
            chk("R5 readback", seq_rd_oe * 32 + seq_rd_data, m_oe * 32 + m_rdd);
            chk("R10 busy", busy, (m_bcnt == 0));
            chk("R9 tag", tag_valid * 8 + result_tag, m_tv * 8 + m_tag);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_mode(input logic [1:0] m);
        mode_sel = m;
        tick(5);
    endtask

    task automatic set_ext(input int a, input int c);
        ext_addr = 3'(a);
        ext_cfg  = 2'(c);
    endtask

    task automatic wr_pulse();
        wr_n = 1'b0; tick(4);
        wr_n = 1'b1; tick(4);
    endtask

    task automatic conv();
        convst_n = 1'b0; tick(4);
        convst_n = 1'b1; tick(4 + B + 3);
    endtask

    task automatic rd_check(input int exp);
        rd_n = 1'b0; tick(4);
        chk("R5 oe high", seq_rd_oe, 1);
        chk("R5 data", seq_rd_data, exp);
        rd_n = 1'b1; tick(4);
        chk("R5 oe low", seq_rd_oe, 0);
    endtask

    // ---------------- directed sequence ----------------
    initial begin
        tick(4);
        chk("R1 busy in reset", busy, 1);
        chk("R1 tag_valid in reset", tag_valid, 0);
        rst_n = 1'b1;
        tick(2);
        chk("R1 mux_addr", mux_addr, 0);
        chk("R1 rd_oe", seq_rd_oe, 0);

        // direct mode
        set_ext(5, 2); wr_pulse();
        chk("R2 capture addr", mux_addr, 5);
        chk("R2 capture cfg", mux_cfg, 2);
        set_ext(3, 1); tick(6);
        chk("R2 pins ignored with wr high", mux_addr, 5);
        conv();
        chk("R2 convst capture", mux_addr, 3);
        chk("R9 tag direct", result_tag, 3);
        set_ext(6, 0); wr_n = 1'b0;
        tick(2);
        chk("R12 not yet", mux_addr, 3);
        tick(1);
        chk("R12 third edge", mux_addr, 6);
        wr_n = 1'b1; tick(4);

        // scan mode
        set_mode(2'b01);
        conv();
        chk("R3 first scan channel", result_tag, 0);
        for (int i = 1; i < 8; i++) conv();
        chk("R3 channel seven", result_tag, 7);
        conv();
        chk("R3 wrap to zero", result_tag, 0);

        // start while busy is dropped
        convst_n = 1'b0; tick(1);
        convst_n = 1'b1; tick(1);
        convst_n = 1'b0; tick(2);
        convst_n = 1'b1; tick(4 + B + 3);
        chk("R10 first start taken", result_tag, 1);
        conv();
        chk("R10 second start dropped", result_tag, 2);

        // edit mode: conversion refused, program three entries
        set_mode(2'b10);
        convst_n = 1'b0; tick(5);
        chk("R11 busy stays high", busy, 1);
        convst_n = 1'b1; tick(4);
        chk("R11 no new tag", result_tag, 2);
        set_ext(2, 1); wr_pulse();
        set_ext(7, 3); wr_pulse();
        set_ext(4, 0); wr_pulse();
        rd_check(9);
        rd_check(31);
        rd_check(16);

        // run mode
        set_mode(2'b11);
        conv();
        chk("R6 first entry", result_tag, 2);
        chk("R6 first cfg", mux_cfg, 1);
        conv();
        conv();
        chk("R6 third entry", result_tag, 4);
        conv();
        chk("R6 wrap after last", result_tag, 2);

        // mode round trip
        set_mode(2'b00);
        set_mode(2'b11);
        conv();
        chk("R7 pointer reset", result_tag, 2);
        chk("R8 sequence kept", mux_cfg, 1);

        // shorter reprogramming pass
        set_mode(2'b10);
        set_ext(5, 2); wr_pulse();
        set_mode(2'b11);
        conv();
        chk("R4 new entry", result_tag, 5);
        conv();
        chk("R4 length shortened", result_tag, 5);
        set_mode(2'b10);
        rd_check(22);
        rd_check(31);
        chk("R8 old entry retained", seq_rd_data, 31);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL R9 watchdog expired actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule